// File: doc/BRIEF.md
# Retimed Coin-Accumulator Vending Controller

This block is a small synchronous controller that adds up nickel and dime pulses toward a fixed price of 15 cents. When the price is reached, it raises an output that releases the product. Credit is held in four states: 0, 5, 10 and 15 cents. A nickel moves the credit up one step. A dime moves it up two steps. Credit never goes past 15 cents. Once 15 cents is reached, the block stays there until reset.

The release output is retimed. Its value is worked out from the present credit and the coins arriving in the same cycle, and that value is captured in a flip-flop. The output therefore rises on the same clock edge that moves the credit to 15 cents, yet it is driven straight from a register with no gates after it. Its cycle-by-cycle behaviour is the same as a transition-output machine whose output passes through one flip-flop.

The coin inputs are one-cycle pulses sampled on the rising clock edge. If a nickel and a dime arrive in the same cycle, the dime wins and the nickel is dropped.

Top module: `coin_vend_ctrl`

## Requirements
- R1: A high `rst` at a rising edge sets `credit` to 2'b00 and `open_out` to 0 at that edge. Reset takes priority over any coin input sampled in the same cycle.
- R2: `credit` encodes the held amount in binary: 2'b00 is 0 cents, 2'b01 is 5 cents, 2'b10 is 10 cents and 2'b11 is 15 cents.
- R3: With `nickel` high and `dime` low at an edge, and credit below 2'b11, `credit` increases by one.
- R4: With `dime` high at an edge, and credit below 2'b11, `credit` increases by two, limited to 2'b11. So 10 cents plus a dime gives 15 cents.
- R5: A cycle with neither coin input high, and reset low, leaves `credit` unchanged.
- R6: Once `credit` is 2'b11, it stays at 2'b11 whatever the coin inputs do, until reset.
- R7: If `nickel` and `dime` are both high in the same cycle, the step taken is exactly the step of a dime alone.
- R8: `open_out` is a register output. It becomes 1 on the same edge that moves `credit` to 2'b11, and it stays 1 while `credit` is 2'b11. It equals, every cycle, a transition-output machine whose output goes through one flip-flop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nickel | input | 1 | One-cycle pulse for a 5-cent coin |
| dime | input | 1 | One-cycle pulse for a 10-cent coin |
| credit | output | 2 | Credit held, binary encoded in 5-cent steps |
| open_out | output | 1 | Registered release output |

## Verification
A vector table steps the block through the following sequences:
- Nickels only, which separates the one-step path from the two-step path.
- Dimes only, which shows the limit when a dime arrives at 10 cents.
- Both coins together in one cycle, which shows dime priority.
- Coins at 15 cents, which shows the state holding.
- Idle cycles, which show the credit holding.
- Reset together with a coin, which shows reset priority.

A long pseudo-random stream of coins with occasional resets is then checked against a model of the transition-output machine plus one flip-flop, kept in the bench. This shows that the retimed release output matches that machine on every cycle, not only at hand-picked points.

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       nickel,
  input  logic       dime,
  output logic [1:0] credit,
  output logic       open_out
);

  localparam logic [1:0] C0  = 2'b00;
  localparam logic [1:0] C5  = 2'b01;
  localparam logic [1:0] C10 = 2'b10;
  localparam logic [1:0] C15 = 2'b11;

  logic [1:0] state_q;
  logic [1:0] state_d;
  logic       open_q;

  always_comb begin
    state_d = state_q;
    if (state_q != C15) begin
      if (dime)
        state_d = (state_q == C0) ? C10 : C15;
      else if (nickel)
        state_d = state_q + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= C0;
      open_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      open_q  <= (state_d == C15);
    end
  end

  assign credit   = state_q;
  assign open_out = open_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (credit == C0 && !open_out));

  // R3
  nickel_step_chk: assert property (@(posedge clk) disable iff (rst)
    (nickel && !dime && credit != C15) |=> credit == $past(credit) + 2'd1);

  // R4 R7
  dime_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dime && credit != C15) |=> credit == (($past(credit) == C0) ? C10 : C15));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!nickel && !dime) |=> $stable(credit));

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (credit == C15) |=> credit == C15);

  // R8
  open_match_chk: assert property (@(posedge clk) disable iff (rst)
    open_out |-> credit == C15);

  // R8
  open_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (credit != C15) |=> (open_out == (credit == C15)));

endmodule

// File: tb/sim_coin_vend_ctrl.sv
`timescale 1ns/1ps
module sim_coin_vend_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nickel = 1'b0;
  logic       dime = 1'b0;
  logic [1:0] credit;
  logic       open_out;

  int checks = 0;
  int errors = 0;

  coin_vend_ctrl u0 (
    .clk(clk), .rst(rst), .nickel(nickel), .dime(dime),
    .credit(credit), .open_out(open_out)
  );

  always #4 clk = ~clk;

  // {rst, nickel, dime, exp_credit[1:0], exp_open}
  localparam int NV = 20;
  localparam logic [5:0] VEC [0:NV-1] = '{
    6'b010_01_0, 6'b000_01_0, 6'b010_10_0, 6'b010_11_1, 6'b010_11_1,
    6'b001_11_1, 6'b100_00_0, 6'b001_10_0, 6'b001_11_1, 6'b100_00_0,
    6'b011_10_0, 6'b010_11_1, 6'b100_00_0, 6'b010_01_0, 6'b001_11_1,
    6'b100_00_0, 6'b011_10_0, 6'b011_11_1, 6'b101_00_0, 6'b000_00_0
  };

  logic [1:0] m_state;
  logic       m_open;

  task automatic check(input string tag, input logic [1:0] ec, input logic eo);
    checks++;
    if (credit !== ec || open_out !== eo) begin
      errors++;
      $display("FAIL %s: credit=%b open=%b expected credit=%b open=%b",
               tag, credit, open_out, ec, eo);
    end
  endtask

  task automatic step(input logic r, input logic n, input logic d);
    logic [1:0] nxt;
    rst = r; nickel = n; dime = d;
    nxt = m_state;
    if (m_state != 2'b11) begin
      if (d) nxt = (m_state == 2'b00) ? 2'b10 : 2'b11;
      else if (n) nxt = m_state + 2'd1;
    end
    if (r) begin
      m_open = 1'b0; m_state = 2'b00;
    end else begin
      m_open = (m_state != 2'b11 && nxt == 2'b11) || (m_state == 2'b11);
      m_state = nxt;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    m_state = 2'b00; m_open = 1'b0;
    @(negedge clk);
    step(1'b1, 1'b1, 1'b1);
    check("R1 reset state", 2'b00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] prev;
      string tag;
      prev = credit;
      if (VEC[i][5])                 tag = "R1 reset";
      else if (prev == 2'b11)        tag = "R6 hold at full";
      else if (VEC[i][4] && VEC[i][3]) tag = "R7 dime priority";
      else if (VEC[i][3])            tag = "R4 dime step";
      else if (VEC[i][4])            tag = "R3 nickel step";
      else                           tag = "R5 idle hold";
      step(VEC[i][5], VEC[i][4], VEC[i][3]);
      check($sformatf("%s R2 vec %0d", tag, i), VEC[i][2:1], VEC[i][0]);
    end

    // R8: open rises on the edge that enters full credit
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    check("R8 before full", 2'b10, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    check("R8 rise with full", 2'b11, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    check("R6 R8 stays full", 2'b11, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    check("R1 reset clears open", 2'b00, 1'b0);

    // R8: random stream against registered transition-output model
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[7:0] == 8'h00 || lfsr[6:2] == 5'h1F, lfsr[0], lfsr[1] & lfsr[3]);
      check($sformatf("R8 model cycle %0d", i), m_state, m_open);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule